// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block gathers the data bytes of one serial-memory write transfer into a small page buffer and, once the transfer is closed, copies them into the memory array during a self-timed write interval. A transfer opens with a one-cycle start pulse that carries the full starting address. The upper address bits select a page row that stays fixed for the whole transfer. The lower bits give a byte offset inside that row. Each received data byte lands at the current offset, and the offset then advances, wrapping inside the row.

The array is written only when the bus side signals STOP, and only if at least one byte arrived. The block then raises `busy` for a fixed, parameterised number of system clocks. During the first page-size cycles of that interval it issues one array write strobe for each slot that holds a byte, in ascending offset order. For the whole busy interval it ignores every input strobe. A write-protect level suppresses all array strobes but leaves the rest of the protocol unchanged. When the interval ends, an address counter is loaded with the address after the last byte received, for later current-address reads.

Top module: `pgc_page_commit`

## Requirements
- R1: After reset `busy` is 0, `arr_we` is 0 and `cur_addr` is 0.
- R2: The page row is `wr_addr[10:4]`. Every array strobe of a transfer carries that row in `arr_addr[10:4]`. Byte k of a transfer (k counting from 0) goes to offset (`wr_addr[3:0]` + k) mod 16, so offset 15 is followed by offset 0.
- R3: When a byte arrives at an offset that is already filled in the same transfer, the newer byte replaces the older one. Only the newest value reaches the array.
- R4: Slot occupancy is cleared by each start pulse. A commit issues exactly one strobe per distinct offset loaded in that transfer, and none for the other offsets.
- R5: No array strobe and no `busy` appear before the STOP strobe of a transfer.
- R6: A STOP that follows at least one byte raises `busy` in the next cycle. `busy` stays high for exactly WAIT_CYC cycles. All array strobes fall inside that interval.
- R7: While `busy` is high, `wr_start`, `byte_vld` and `stop_evt` have no effect on array contents, strobe count, busy length or `cur_addr`.
- R8: While `wp` is 1, `arr_we` stays 0. A protected transfer still collects bytes and runs the full busy interval.
- R9: A STOP with no byte since the start pulse causes no busy interval and no strobe, and leaves `cur_addr` unchanged.
- R10: When the busy interval ends, `cur_addr` becomes (address of the last byte received + 1) mod 2^11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | One-cycle pulse that opens a write transfer |
| wr_addr | input | 11 | Starting address, sampled with `wr_start` |
| byte_vld | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | 8 | Data byte qualified by `byte_vld` |
| stop_evt | input | 1 | One-cycle strobe marking bus STOP |
| wp | input | 1 | Write-protect level, 1 blocks array writes |
| busy | output | 1 | High during the self-timed write interval |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |
| cur_addr | output | 11 | Address counter after the last commit |

## Verification
The bench shortens the write interval to 24 cycles and keeps the 11-bit address and 16-byte page. This lets it sweep every starting offset with lengths of 1, 5, 16 and 19 bytes across many rows. The sweep covers single-byte, partial-page, exact-page and wrapped overwrite transfers. The short interval also leaves room for protected transfers, empty transfers and bus activity injected during `busy`. Each of these is compared against a full 2048-byte reference array computed in the bench.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BUSY = 2'd2
    } pgc_state_e;
endpackage

// File: rtl/pgc_page_store.sv
module pgc_page_store #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               ld,
    input  logic [IDX_W-1:0]                   ld_idx,
    input  logic [DATA_W-1:0]                  ld_data,
    output logic [PAGE_BYTES-1:0]              slot_vld,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  slot_data
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.vld = '0;
        end else if (ld) begin
            s_d.vld[ld_idx] = 1'b1;
            s_d.dat[ld_idx] = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_vld  = s_q.vld;
    assign slot_data = s_q.dat;
endmodule

// File: rtl/pgc_cycle_timer.sv
module pgc_cycle_timer #(
    parameter int WAIT_CYC = 1250000,
    localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_cyc;

    assign last_cyc = t_q.run && (t_q.cnt == CNT_W'(WAIT_CYC - 1));

    always_comb begin
        t_d = t_q;
        if (t_q.run) begin
            if (last_cyc) begin
                t_d.run = 1'b0;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end else if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign run  = t_q.run;
    assign cnt  = t_q.cnt;
    assign done = last_cyc;
endmodule

// File: rtl/pgc_page_commit.sv
module pgc_page_commit #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WAIT_CYC   = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              wp,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] cur_addr
);
    import pgc_pkg::*;

    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int ROW_W = ADDR_W - IDX_W;
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        pgc_state_e        st;
        logic [ROW_W-1:0]  row;
        logic [IDX_W-1:0]  ofs;
        logic [IDX_W-1:0]  last;
        logic              any;
        logic [ADDR_W-1:0] cur;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                              st_clr, st_ld, tmr_go;
    logic                              tmr_run, tmr_done;
    logic [CNT_W-1:0]                  tmr_cnt;
    logic [PAGE_BYTES-1:0]             slot_vld;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
    logic [IDX_W-1:0]                  scan_idx;
    logic                              in_window;

    pgc_page_store #(
        .PAGE_BYTES(PAGE_BYTES),
        .DATA_W    (DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st_clr),
        .ld       (st_ld),
        .ld_idx   (c_q.ofs),
        .ld_data  (byte_data),
        .slot_vld (slot_vld),
        .slot_data(slot_data)
    );

    pgc_cycle_timer #(
        .WAIT_CYC(WAIT_CYC)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_go),
        .run  (tmr_run),
        .cnt  (tmr_cnt),
        .done (tmr_done)
    );

    always_comb begin
        c_d    = c_q;
        st_clr = 1'b0;
        st_ld  = 1'b0;
        tmr_go = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (wr_start) begin
                    c_d.st  = ST_FILL;
                    c_d.row = wr_addr[ADDR_W-1:IDX_W];
                    c_d.ofs = wr_addr[IDX_W-1:0];
                    c_d.any = 1'b0;
                    st_clr  = 1'b1;
                end
            end
            ST_FILL: begin
                if (stop_evt) begin
                    c_d.st = c_q.any ? ST_BUSY : ST_IDLE;
                    tmr_go = c_q.any;
                end else if (wr_start) begin
                    c_d.row = wr_addr[ADDR_W-1:IDX_W];
                    c_d.ofs = wr_addr[IDX_W-1:0];
                    c_d.any = 1'b0;
                    st_clr  = 1'b1;
                end else if (byte_vld) begin
                    st_ld    = 1'b1;
                    c_d.last = c_q.ofs;
                    c_d.ofs  = c_q.ofs + 1'b1;
                    c_d.any  = 1'b1;
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    c_d.st  = ST_IDLE;
                    c_d.cur = {c_q.row, c_q.last} + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign scan_idx  = tmr_cnt[IDX_W-1:0];
    assign in_window = tmr_cnt < CNT_W'(PAGE_BYTES);
    assign busy      = tmr_run;
    assign arr_we    = tmr_run && in_window && slot_vld[scan_idx] && !wp;
    assign arr_addr  = {c_q.row, scan_idx};
    assign arr_wdata = slot_data[scan_idx];
    assign cur_addr  = c_q.cur;
endmodule

// File: rtl/pgc_page_commit_chk.sv
module pgc_page_commit_chk #(
    parameter int ADDR_W   = 11,
    parameter int WAIT_CYC = 1250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              wp,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam int IDX_W = 4;

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !arr_we);

    a_r2_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) && busy && $past(busy)
        |-> arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W]));

    a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    a_r6_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < CNT_W'(WAIT_CYC));

    a_r6_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(run_q) == CNT_W'(WAIT_CYC - 1));

    a_r7_cur_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cur_addr));

    a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !arr_we);
endmodule

bind pgc_page_commit pgc_page_commit_chk #(
    .ADDR_W  (ADDR_W),
    .WAIT_CYC(WAIT_CYC)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_evt(stop_evt),
    .wp      (wp),
    .busy    (busy),
    .arr_we  (arr_we),
    .arr_addr(arr_addr),
    .cur_addr(cur_addr)
);

// File: tb/pgc_page_commit_tb.sv
module pgc_page_commit_top_tb_top;
    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int WAIT = 24;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_evt = 1'b0;
    logic          wp = 1'b0;
    logic          busy, arr_we;
    logic [AW-1:0] arr_addr, cur_addr;
    logic [DW-1:0] arr_wdata;

    logic [DW-1:0] exp_mem [MEMN];
    logic [DW-1:0] dut_mem [MEMN];
    int            n_chk = 0, n_fail = 0, strobes = 0, cyc = 0;
    logic [AW-1:0] exp_cur = '0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    pgc_page_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(16), .WAIT_CYC(WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .cur_addr(cur_addr)
    );

    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            strobes++;
            dut_mem[arr_addr] = arr_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mem_check(input string req);
        int bad = 0;
        for (int i = 0; i < MEMN; i++) if (dut_mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    // One transfer: start, n bytes, stop, then measure the busy interval.
    task automatic xfer(input int row, input int s, input int n, input bit prot,
                        input bit inject, input int seed);
        int  busy_len = 0;
        int  st0;
        bit  early = 0;
        bit  seen[16];
        int  distinct = 0;
        for (int k = 0; k < 16; k++) seen[k] = 0;
        @(negedge clk);
        wp       = prot;
        st0      = strobes;
        wr_start = 1'b1;
        wr_addr  = AW'((row << 4) | s);
        @(negedge clk);
        wr_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            int off = (s + k) % 16;
            byte_vld  = 1'b1;
            byte_data = DW'(seed * 37 + k * 5 + 1);
            if (!prot) exp_mem[(row << 4) | off] = byte_data;
            if (!seen[off]) begin seen[off] = 1; distinct++; end
            @(negedge clk);
            if (busy || strobes != st0) early = 1;
        end
        byte_vld = 1'b0;
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        while (busy && busy_len < 4 * WAIT) begin
            busy_len++;
            wr_start = inject && busy_len == 2;
            wr_addr  = inject ? AW'(MEMN - 16) : wr_addr;
            byte_vld = inject && busy_len == 3;
            stop_evt = inject && busy_len == 4;
            byte_data = 8'hEE;
            @(negedge clk);
        end
        wr_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
        check(!early, "R5 no busy or strobe before stop", early, 0);
        if (n > 0) begin
            exp_cur = AW'(((row << 4) | ((s + n - 1) % 16)) + 1);
            check(busy_len == WAIT, inject ? "R7 busy length with bus noise" : "R6 busy length",
                  busy_len, WAIT);
        end else begin
            check(busy_len == 0, "R9 empty transfer gives no busy", busy_len, 0);
        end
        check(strobes - st0 == (prot ? 0 : distinct),
              prot ? "R8 no strobe under protect" : "R4 one strobe per loaded slot",
              strobes - st0, prot ? 0 : distinct);
        mem_check(inject ? "R7 array untouched by noise" : (n > 16 ? "R3 overwrite wins" : "R2 placement"));
        check(cur_addr == exp_cur, n > 0 ? "R10 address counter" : "R9 counter unchanged",
              cur_addr, exp_cur);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < MEMN; i++) begin exp_mem[i] = '0; dut_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1 strobe after reset", arr_we, 0);
        check(cur_addr == '0, "R1 counter after reset", cur_addr, 0);
        rst_n = 1'b1;
        for (int s = 0; s < 16; s++) begin
            for (int li = 0; li < 4; li++) begin
                int lens[4] = '{1, 5, 16, 19};
                xfer((s * 7 + li * 3) % 128, s, lens[li], 1'b0, li == 2, s * 4 + li);
            end
        end
        xfer(127, 15, 1, 1'b0, 1'b0, 90);   // R10 roll-over of the counter to 0
        xfer(5, 9, 7, 1'b1, 1'b0, 91);      // R8 protected transfer
        xfer(9, 3, 0, 1'b0, 1'b0, 92);      // R9 stop without data
        xfer(5, 0, 16, 1'b0, 1'b0, 93);     // R4 full row after protected one
        xfer(5, 2, 1, 1'b0, 1'b0, 94);      // R4 occupancy cleared by new start
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule